// File: doc/BRIEF.md
# Count/Limit Interval Timer

This block is an up-counting interval timer driven by an external enable tick. A counter advances by one on each qualifying tick. When a tick arrives while the counter equals the programmed limit, the counter restarts from zero and a sticky pending flag is set in the control register. If interrupts are enabled and the flag was clear before that expiry, a level interrupt line is raised. Software lowers the line by writing control with the pending flag cleared.

Three registers sit on a plain single-cycle register bus: control, count and limit. Writing count preloads the counter, and counting carries on from the written value. Writing limit changes the comparison at once, for the count cycle already in progress. A control bit can suspend counting while the host reports itself halted. Reads are combinational from the current register state.

Top module: `limit_timer`

## Requirements
- R1: After reset, control reads 0, count reads 0, limit reads the LIMIT_RESET parameter (default 0x00FFFFFF) and irq is low.
- R2: Control is 5 bits: bit 0 interrupt enable, bit 1 pause-when-halted, bit 2 watchdog select (stored only), bit 3 pending flag, bit 4 spare (stored only). A control write keeps only bits [4:0], and bits above 4 read as zero.
- R3: On each cycle with tickEn high, the count increases by one, unless control bit 1 is set and halted is high, in which case the count holds.
- R4: A counting tick while count equals limit sets count to 0 and sets the pending flag (control bit 3).
- R5: An expiry raises irq only when the enable bit is 1 and the pending flag was 0 just before that expiry; with the enable bit 0, the expiry sets the flag and irq stays low.
- R6: An expiry while the pending flag is already set (by an earlier expiry or by software) does not raise irq.
- R7: A control write that takes the pending flag from 1 to 0 drops irq in the same edge; a control write that leaves the flag at 1 leaves irq unchanged.
- R8: A write to count (address 1) loads the counter with the written value, truncated to CNT_W bits. A count write in the same cycle as a tick wins, and no expiry occurs in that cycle.
- R9: A limit write (address 2) applies from the next tick. When the new limit is below the current count, the counter runs up, wraps through zero at 2^CNT_W without an expiry, and expires when it later equals the limit.
- R10: A control write in the same cycle as an expiry stores the written value in every control bit, and that expiry raises no irq. The count still restarts from zero.
- R11: The read address selects the register: 0 control, 1 count, 2 limit. Address 3 reads zero. Narrower registers are zero-extended to DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count enable tick |
| halted | input | 1 | Host halted indication; pauses counting when control bit 1 is set |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 count, 2 limit |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr, combinational |
| irq | output | 1 | Timer interrupt line |

## Verification
The bench builds the timer with CNT_W = 24 and LIMIT_RESET = 24'hFFFFFF on a 32-bit bus. With these values the reset limit is the all-ones counter value, and the bus carries upper bits that control and count must drop. A counter preloaded just below 2^24 wraps through zero in a few ticks, so the bench can observe a wrap with no expiry when the limit lies below the count. Small programmed limits keep expiries a handful of ticks apart. This is how the bench reaches repeated expiries with the flag still set, and a write and an expiry in the same cycle.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

  // control register layout
  localparam int CTRL_W  = 5;
  localparam int IE_BIT  = 0;
  localparam int NH_BIT  = 1;
  localparam int WD_BIT  = 2;
  localparam int IP_BIT  = 3;
  localparam int PD_BIT  = 4;

  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_LIMIT = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic loadCount;
    logic loadLimit;
  } dpStrobe_t;

endpackage

// File: rtl/ltmr_ctrl.sv
module ltmr_ctrl
  import ltmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              halted,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wrCtrl,
  input  logic              expire,
  output dpStrobe_t         strobe,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              irqQ
);

  logic ctrlWr;
  logic flagWasSet;

  assign ctrlWr     = wrEn && (addr == SEL_CTRL);
  assign flagWasSet = ctrlQ[IP_BIT];

  // counting is paused when the pause bit is set and the host is halted
  always_comb begin
    strobe.advance   = tickEn && !(ctrlQ[NH_BIT] && halted);
    strobe.loadCount = wrEn && (addr == SEL_COUNT);
    strobe.loadLimit = wrEn && (addr == SEL_LIMIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      irqQ  <= 1'b0;
    end else if (ctrlWr) begin
      // software write owns every control bit in this cycle
      ctrlQ <= wrCtrl;
      if (flagWasSet && !wrCtrl[IP_BIT]) irqQ <= 1'b0;
    end else if (expire) begin
      ctrlQ[IP_BIT] <= 1'b1;
      if (ctrlQ[IE_BIT] && !flagWasSet) irqQ <= 1'b1;
    end
  end

endmodule

// File: rtl/ltmr_dpath.sv
module ltmr_dpath
  import ltmr_pkg::*;
#(
  parameter int              CNT_W       = 32,
  parameter int              DATA_W      = 32,
  parameter logic [CNT_W-1:0] LIMIT_RESET = CNT_W'(24'hFFFFFF)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CNT_W-1:0]  wrValue,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] ctrlQ,
  output logic              expire,
  output logic [CNT_W-1:0]  countQ,
  output logic [CNT_W-1:0]  limitQ,
  output logic [DATA_W-1:0] rdData
);

  logic atLimit;

  assign atLimit = (countQ == limitQ);
  // a count write in the same cycle wins over the tick
  assign expire  = strobe.advance && atLimit && !strobe.loadCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.loadCount) begin
      countQ <= wrValue;
    end else if (strobe.advance) begin
      countQ <= atLimit ? '0 : countQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 limitQ <= LIMIT_RESET;
    else if (strobe.loadLimit) limitQ <= wrValue;
  end

  always_comb begin
    unique case (regSel_e'(addr))
      SEL_CTRL:  rdData = DATA_W'(ctrlQ);
      SEL_COUNT: rdData = DATA_W'(countQ);
      SEL_LIMIT: rdData = DATA_W'(limitQ);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/limit_timer.sv
module limit_timer
  import ltmr_pkg::*;
#(
  parameter int              CNT_W       = 32,
  parameter int              DATA_W      = 32,
  parameter logic [CNT_W-1:0] LIMIT_RESET = CNT_W'(24'hFFFFFF)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              halted,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  dpStrobe_t         strobe;
  logic              expire;
  logic [CTRL_W-1:0] ctrlQ;
  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  limitQ;

  ltmr_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .halted (halted),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrCtrl (wrData[CTRL_W-1:0]),
    .expire (expire),
    .strobe (strobe),
    .ctrlQ  (ctrlQ),
    .irqQ   (irq)
  );

  ltmr_dpath #(
    .CNT_W       (CNT_W),
    .DATA_W      (DATA_W),
    .LIMIT_RESET (LIMIT_RESET)
  ) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrValue (wrData[CNT_W-1:0]),
    .addr    (addr),
    .ctrlQ   (ctrlQ),
    .expire  (expire),
    .countQ  (countQ),
    .limitQ  (limitQ),
    .rdData  (rdData)
  );

endmodule

// File: rtl/limit_timer_chk.sv
module limit_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              halted,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic [4:0]        ctrlQ,
  input logic [CNT_W-1:0]  countQ,
  input logic [CNT_W-1:0]  limitQ,
  input logic              irq
);

  // R3: a plain tick below the limit steps the count by one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !(ctrlQ[1] && halted) && !(wrEn && addr == 2'd1) && countQ != limitQ)
    |=> countQ == $past(countQ) + 1'b1);

  // R4: a tick at the limit restarts the count and marks pending
  p_expire_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !(ctrlQ[1] && halted) && !(wrEn && addr == 2'd1) && countQ == limitQ
     && !(wrEn && addr == 2'd0))
    |=> countQ == '0 && ctrlQ[3]);

  // R5, R6: the line rises only from an enabled expiry with the flag clear before
  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(ctrlQ[0]) && !$past(ctrlQ[3]) && ctrlQ[3]);

  // R7: the line falls only on a control write clearing the flag
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(wrEn && addr == 2'd0 && !wrData[3]) && !ctrlQ[3]);

  // R8: a count write loads the counter
  p_count_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1) |=> countQ == $past(wrData[CNT_W-1:0]));

  // R2: without a control write only the pending bit may change
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 2'd0) |=> ctrlQ[2:0] == $past(ctrlQ[2:0]) && ctrlQ[4] == $past(ctrlQ[4]));

endmodule

bind limit_timer limit_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .tickEn (tickEn),
  .halted (halted),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .ctrlQ  (ctrlQ),
  .countQ (countQ),
  .limitQ (limitQ),
  .irq    (irq)
);

// File: tb/test_limit_timer.sv
`timescale 1ns/1ps
module test_limit_timer;

  localparam int CNT_W  = 24;
  localparam int DATA_W = 32;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickEn = 1'b0;
  logic              halted = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  limit_timer #(
    .CNT_W       (CNT_W),
    .DATA_W      (DATA_W),
    .LIMIT_RESET (24'hFFFFFF)
  ) i_limit_timer (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .halted (halted),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .irq    (irq)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] expRd;
    logic        expIrq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 32'h0,        32'h0,        1'b0, 4'd1},  // R1 control
    '{2'd1, 2'd1, 32'h0,        32'h0,        1'b0, 4'd1},  // R1 count
    '{2'd1, 2'd2, 32'h0,        32'hFFFFFF,   1'b0, 4'd1},  // R1 limit
    '{2'd0, 2'd0, 32'hFFFFFFE1, 32'h0,        1'b0, 4'd2},  // R2 wide write
    '{2'd1, 2'd0, 32'h0,        32'h1,        1'b0, 4'd2},  // R2 only IE kept
    '{2'd0, 2'd2, 32'h3,        32'h0,        1'b0, 4'd9},  // R9 limit 3
    '{2'd2, 2'd0, 32'd3,        32'h0,        1'b0, 4'd3},  // R3 three ticks
    '{2'd1, 2'd1, 32'h0,        32'h3,        1'b0, 4'd3},  // R3 count 3
    '{2'd2, 2'd0, 32'd1,        32'h0,        1'b1, 4'd5},  // R5 expiry raises
    '{2'd1, 2'd1, 32'h0,        32'h0,        1'b1, 4'd4},  // R4 restart
    '{2'd1, 2'd0, 32'h0,        32'h9,        1'b1, 4'd4},  // R4 flag set
    '{2'd2, 2'd0, 32'd4,        32'h0,        1'b1, 4'd6},  // R6 second expiry
    '{2'd0, 2'd0, 32'h9,        32'h0,        1'b1, 4'd7},  // R7 flag kept
    '{2'd0, 2'd0, 32'h1,        32'h0,        1'b0, 4'd7},  // R7 flag cleared
    '{2'd0, 2'd0, 32'h9,        32'h0,        1'b0, 4'd6},  // R6 sw sets flag
    '{2'd2, 2'd0, 32'd4,        32'h0,        1'b0, 4'd6},  // R6 no raise
    '{2'd1, 2'd1, 32'h0,        32'h0,        1'b0, 4'd4},  // R4 restart
    '{2'd0, 2'd0, 32'h0,        32'h0,        1'b0, 4'd5},  // R5 disable
    '{2'd2, 2'd0, 32'd4,        32'h0,        1'b0, 4'd5},  // R5 silent expiry
    '{2'd1, 2'd0, 32'h0,        32'h8,        1'b0, 4'd5},  // R5 flag only
    '{2'd0, 2'd1, 32'h2,        32'h0,        1'b0, 4'd8},  // R8 preload
    '{2'd1, 2'd1, 32'h0,        32'h2,        1'b0, 4'd8},  // R8 loaded
    '{2'd2, 2'd0, 32'd1,        32'h0,        1'b0, 4'd8},  // R8 continues
    '{2'd1, 2'd1, 32'h0,        32'h3,        1'b0, 4'd8}   // R8 count 3
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end 1 ns after a rising edge
  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(posedge clk);
    #1 tickEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic readCheck(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    readReg(a, v);
    check(req, $sformatf("read addr %0d", a), v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      case (VECS[i].kind)
        K_WR: busWrite(VECS[i].addr, VECS[i].data);
        K_TK: ticks(int'(VECS[i].data));
        default: begin
          readReg(VECS[i].addr, v);
          check(tag, $sformatf("vec %0d rdData", i), v, VECS[i].expRd);
        end
      endcase
      #1;
      check(tag, $sformatf("vec %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].expIrq});
    end

    // R3: pause-when-halted gating
    busWrite(2'd0, 32'h2);
    busWrite(2'd2, 32'd100);
    busWrite(2'd1, 32'd0);
    halted = 1'b1; ticks(5);
    readCheck("R3", 2'd1, 32'd0);
    halted = 1'b0; ticks(5);
    readCheck("R3", 2'd1, 32'd5);
    busWrite(2'd0, 32'h0);
    halted = 1'b1; ticks(2);
    readCheck("R3", 2'd1, 32'd7);
    halted = 1'b0;

    // R9: lowered limit applies to the running count
    busWrite(2'd2, 32'd8);
    ticks(1);
    readCheck("R9", 2'd1, 32'd8);
    readCheck("R9", 2'd0, 32'h0);
    ticks(1);
    readCheck("R9", 2'd1, 32'd0);
    readCheck("R9", 2'd0, 32'h8);

    // R9: limit below count wraps through zero without expiry
    busWrite(2'd0, 32'h0);
    busWrite(2'd1, 32'hFFFFFE);
    busWrite(2'd2, 32'd5);
    ticks(2);
    readCheck("R9", 2'd1, 32'd0);
    readCheck("R9", 2'd0, 32'h0);
    ticks(5);
    readCheck("R9", 2'd1, 32'd5);
    readCheck("R9", 2'd0, 32'h0);
    ticks(1);
    readCheck("R9", 2'd1, 32'd0);
    readCheck("R9", 2'd0, 32'h8);

    // R8: count write beats a tick at the limit
    busWrite(2'd0, 32'h1);
    busWrite(2'd2, 32'd4);
    busWrite(2'd1, 32'd4);
    tickEn = 1'b1;
    busWrite(2'd1, 32'd1);
    tickEn = 1'b0;
    readCheck("R8", 2'd1, 32'd1);
    readCheck("R8", 2'd0, 32'h1);
    check("R8", "irq", {31'b0, irq}, 32'd0);
    ticks(1);
    readCheck("R8", 2'd1, 32'd2);

    // R10: control write in the expiry cycle wins
    busWrite(2'd1, 32'd4);
    tickEn = 1'b1;
    busWrite(2'd0, 32'h1);
    tickEn = 1'b0;
    readCheck("R10", 2'd0, 32'h1);
    readCheck("R10", 2'd1, 32'd0);
    check("R10", "irq", {31'b0, irq}, 32'd0);
    ticks(5);
    check("R5", "irq after clean expiry", {31'b0, irq}, 32'd1);

    // R11: unused address
    readCheck("R11", 2'd3, 32'h0);
    readCheck("R11", 2'd2, 32'd4);

    // R1: reset in mid-run
    rstN = 1'b0; #1;
    check("R1", "irq in reset", {31'b0, irq}, 32'd0);
    readCheck("R1", 2'd2, 32'hFFFFFF);
    readCheck("R1", 2'd0, 32'h0);
    readCheck("R1", 2'd1, 32'h0);
    @(posedge clk); #1 rstN = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule